// File: doc/BRIEF.md
# Static Branch Direction Predictor with Execute-Stage Correction

This block sits at the decode stage of a simple in-order pipeline. Each decoded instruction is classified as one of four kinds: an unconditional relative jump, a conditional relative branch, a branch whose target comes from a register, or a non-branch. A fixed rule, with no history, predicts the branch direction from the kind and from the sign of the displacement. When the prediction is taken, the block computes the target and sends a redirect request toward fetch. The instruction then moves downstream with its prediction bit attached.

A small checker on the execute side takes the resolved direction and target of a branch, together with the prediction that travelled with it. It raises a corrective redirect only when the resolved direction differs from the prediction. A corrective redirect wins over a decode redirect in the same cycle and cancels it. While any redirect is being presented, newly decoded instructions are squashed.

Instruction encoding (32 bits):
- Bits [31:28] give the kind: 4'hA is an unconditional jump, 4'hB is a conditional branch, 4'hC is a register-target branch, and any other value is not a branch.
- Bit 27 selects absolute addressing.
- The jump displacement is in bits [23:0]. The conditional displacement is in bits [15:0].
- Both displacements count words and are signed.

All outputs are registered and appear one clock after the inputs they depend on.

Top module: `bp_static_predict`

## Requirements
- R1: A valid instruction of kind 4'hA is always predicted taken. One cycle later, redirectValid=1, redirectFromExec=0, and redirectAddr equals insnPc plus the sign-extended bits [23:0] shifted left by 2.
- R2: A valid instruction of kind 4'hB is predicted taken exactly when bit 15 (the displacement sign) is 1. When taken, it redirects to insnPc plus the sign-extended bits [15:0] shifted left by 2. When not taken, no redirect is raised.
- R3: A valid instruction of kind 4'hC is always predicted not taken and raises no decode redirect.
- R4: An instruction of any other kind has dnPredTaken=0 and raises no decode redirect.
- R5: When bit 27 is 1, the predicted target is the sign-extended, shifted displacement alone, with no insnPc added.
- R6: A surviving instruction appears one cycle later on dnValid, dnInsn, dnPc and dnPredTaken, with dnPredTaken equal to the prediction.
- R7: When exValid=1 and exPredTaken differs from exTaken, a redirect with redirectFromExec=1 follows one cycle later. Its address is exTarget when exTaken=1 and exPc+4 when exTaken=0. A matching prediction raises no redirect from execute.
- R8: A corrective redirect cancels a decode redirect raised in the same cycle, and that decoded instruction is not passed downstream.
- R9: When insnValid=0, there is no decode redirect and dnValid is 0 one cycle later.
- R10: While redirectValid=1, an incoming decoded instruction is squashed: it raises no decode redirect and gives dnValid=0 on the next cycle.
- R11: While reset is held, redirectValid, redirectFromExec, dnValid and dnPredTaken are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| insnValid | input | 1 | Decode-stage instruction is valid |
| insn | input | 32 | Instruction word |
| insnPc | input | ADDR_W | Instruction address |
| exValid | input | 1 | Execute stage holds a resolved branch |
| exPredTaken | input | 1 | Prediction carried with the executing branch |
| exTaken | input | 1 | Resolved direction |
| exTarget | input | ADDR_W | Resolved taken target |
| exPc | input | ADDR_W | Address of the executing branch |
| redirectValid | output | 1 | Flush and redirect request to fetch |
| redirectFromExec | output | 1 | Request is a corrective one from execute |
| redirectAddr | output | ADDR_W | Redirect address |
| dnValid | output | 1 | Downstream instruction valid |
| dnInsn | output | 32 | Downstream instruction word |
| dnPc | output | ADDR_W | Downstream instruction address |
| dnPredTaken | output | 1 | Prediction bit attached to the instruction |

## Verification
Every result of this block, whether the decode redirect, the corrective redirect or the downstream copy with its prediction bit, is due exactly one clock edge after the inputs that cause it. The bench drives inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge. Its model tracks whether a redirect is already showing, so that squashing under R10 is predicted for the same cycle in which the design applies it.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int INSN_W   = 32;
  localparam int KIND_MSB = 31;
  localparam int KIND_LSB = 28;
  localparam int ABS_BIT  = 27;
  localparam int JDISP_W  = 24;
  localparam int CDISP_W  = 16;

  localparam logic [3:0] KIND_JUMP  = 4'hA;
  localparam logic [3:0] KIND_CBR   = 4'hB;
  localparam logic [3:0] KIND_REGBR = 4'hC;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_JUMP,
    CLS_CBR,
    CLS_REG
  } brClass_e;

  typedef struct packed {
    brClass_e cls;
    logic     dispNeg;
  } brInfo_t;

  typedef struct packed {
    logic loadRedirect;
    logic selExec;
    logic passDown;
  } strobe_t;
endpackage

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INSN_W-1:0] insn,
  input  logic [ADDR_W-1:0] insnPc,
  input  logic              exTaken,
  input  logic [ADDR_W-1:0] exTarget,
  input  logic [ADDR_W-1:0] exPc,
  input  strobe_t           strobes,
  output brInfo_t           info,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic [INSN_W-1:0] dnInsn,
  output logic [ADDR_W-1:0] dnPc
);
  localparam int JPAD = ADDR_W - JDISP_W - 2;
  localparam int CPAD = ADDR_W - CDISP_W - 2;

  logic [3:0]        kind;
  logic              absMode;
  logic [ADDR_W-1:0] jumpOff;
  logic [ADDR_W-1:0] condOff;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] decTarget;
  logic [ADDR_W-1:0] fixAddr;

  assign kind    = insn[KIND_MSB:KIND_LSB];
  assign absMode = insn[ABS_BIT];

  always_comb begin
    unique case (kind)
      KIND_JUMP:  info.cls = CLS_JUMP;
      KIND_CBR:   info.cls = CLS_CBR;
      KIND_REGBR: info.cls = CLS_REG;
      default:    info.cls = CLS_NONE;
    endcase
    info.dispNeg = (info.cls == CLS_JUMP) ? insn[JDISP_W-1] : insn[CDISP_W-1];
  end

  assign jumpOff   = {{JPAD{insn[JDISP_W-1]}}, insn[JDISP_W-1:0], 2'b00};
  assign condOff   = {{CPAD{insn[CDISP_W-1]}}, insn[CDISP_W-1:0], 2'b00};
  assign baseAddr  = absMode ? '0 : insnPc;
  assign decTarget = baseAddr + ((info.cls == CLS_JUMP) ? jumpOff : condOff);
  assign fixAddr   = exTaken ? exTarget : exPc + ADDR_W'(4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirectAddr <= '0;
      dnInsn       <= '0;
      dnPc         <= '0;
    end else begin
      if (strobes.loadRedirect)
        redirectAddr <= strobes.selExec ? fixAddr : decTarget;
      if (strobes.passDown) begin
        dnInsn <= insn;
        dnPc   <= insnPc;
      end
    end
  end
endmodule

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    insnValid,
  input  brInfo_t info,
  input  logic    exValid,
  input  logic    exPredTaken,
  input  logic    exTaken,
  output strobe_t strobes,
  output logic    redirectValid,
  output logic    redirectFromExec,
  output logic    dnValid,
  output logic    dnPredTaken
);
  logic predictTaken;
  logic exMiss;
  logic live;
  logic decFire;

  assign predictTaken = (info.cls == CLS_JUMP) || ((info.cls == CLS_CBR) && info.dispNeg);
  assign exMiss       = exValid && (exPredTaken != exTaken);
  assign live         = insnValid && !exMiss && !redirectValid;
  assign decFire      = live && predictTaken;

  assign strobes.loadRedirect = exMiss || decFire;
  assign strobes.selExec      = exMiss;
  assign strobes.passDown     = live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirectValid    <= 1'b0;
      redirectFromExec <= 1'b0;
      dnValid          <= 1'b0;
      dnPredTaken      <= 1'b0;
    end else begin
      redirectValid    <= exMiss || decFire;
      redirectFromExec <= exMiss;
      dnValid          <= live;
      dnPredTaken      <= decFire;
    end
  end

  assert_exec_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    exMiss |=> (redirectValid && redirectFromExec && !dnValid));

  assert_regbr_not_taken_R3: assert property (@(posedge clk) disable iff (!rstN)
    (insnValid && info.cls == CLS_REG && !(exValid && exPredTaken != exTaken)) |=>
      (!dnPredTaken && !redirectValid));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!insnValid && !exValid) |=> (!redirectValid && !dnValid));

  assert_busy_squash_R10: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && !exValid) |=> (!redirectValid && !dnValid));

  assert_match_no_fix_R7: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exPredTaken == exTaken) |=> !redirectFromExec);
endmodule

// File: rtl/bp_static_predict.sv
module bp_static_predict
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insnValid,
  input  logic [31:0]       insn,
  input  logic [ADDR_W-1:0] insnPc,
  input  logic              exValid,
  input  logic              exPredTaken,
  input  logic              exTaken,
  input  logic [ADDR_W-1:0] exTarget,
  input  logic [ADDR_W-1:0] exPc,
  output logic              redirectValid,
  output logic              redirectFromExec,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic              dnValid,
  output logic [31:0]       dnInsn,
  output logic [ADDR_W-1:0] dnPc,
  output logic              dnPredTaken
);
  brInfo_t info;
  strobe_t strobes;

  bp_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .insn(insn), .insnPc(insnPc),
    .exTaken(exTaken), .exTarget(exTarget), .exPc(exPc),
    .strobes(strobes), .info(info), .redirectAddr(redirectAddr),
    .dnInsn(dnInsn), .dnPc(dnPc)
  );

  bp_control u_ctl (
    .clk(clk), .rstN(rstN), .insnValid(insnValid), .info(info),
    .exValid(exValid), .exPredTaken(exPredTaken), .exTaken(exTaken),
    .strobes(strobes), .redirectValid(redirectValid),
    .redirectFromExec(redirectFromExec), .dnValid(dnValid),
    .dnPredTaken(dnPredTaken)
  );
endmodule

// File: tb/bp_static_predict_tb.sv
`timescale 1ns/1ps
module bp_static_predict_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insnValid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] insnPc = '0;
  logic        exValid = 1'b0;
  logic        exPredTaken = 1'b0;
  logic        exTaken = 1'b0;
  logic [31:0] exTarget = '0;
  logic [31:0] exPc = '0;
  logic        redirectValid, redirectFromExec, dnValid, dnPredTaken;
  logic [31:0] redirectAddr, dnInsn, dnPc;

  int checks = 0;
  int failures = 0;
  logic expRv = 1'b0;

  always #2.5 clk = ~clk;

  bp_static_predict u_dut (
    .clk(clk), .rstN(rstN), .insnValid(insnValid), .insn(insn), .insnPc(insnPc),
    .exValid(exValid), .exPredTaken(exPredTaken), .exTaken(exTaken),
    .exTarget(exTarget), .exPc(exPc), .redirectValid(redirectValid),
    .redirectFromExec(redirectFromExec), .redirectAddr(redirectAddr),
    .dnValid(dnValid), .dnInsn(dnInsn), .dnPc(dnPc), .dnPredTaken(dnPredTaken)
  );

  function automatic logic predictOf(input logic [31:0] w);
    return (w[31:28] == 4'hA) || (w[31:28] == 4'hB && w[15]);
  endfunction

  function automatic logic [31:0] targetOf(input logic [31:0] w, input logic [31:0] p);
    logic [31:0] off;
    off = (w[31:28] == 4'hA) ? {{6{w[23]}}, w[23:0], 2'b00} : {{14{w[15]}}, w[15:0], 2'b00};
    return (w[27] ? 32'd0 : p) + off;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [31:0] w, input logic [31:0] p,
                      input logic ev, input logic ep, input logic et,
                      input logic [31:0] etg, input logic [31:0] epc);
    logic miss, live, pr, nRv, nFe;
    logic [31:0] nAddr;
    string tag;
    insnValid = iv; insn = w; insnPc = p;
    exValid = ev; exPredTaken = ep; exTaken = et; exTarget = etg; exPc = epc;
    miss = ev && (ep != et);
    live = iv && !miss && !expRv;
    pr = predictOf(w);
    nRv = miss || (live && pr);
    nFe = miss;
    nAddr = miss ? (et ? etg : epc + 32'd4) : targetOf(w, p);
    if (miss) tag = (iv && pr && !expRv) ? "R8" : "R7";
    else if (ev && !(live && pr)) tag = "R7";
    else if (!iv) tag = "R9";
    else if (expRv) tag = "R10";
    else if (pr && w[27]) tag = "R5";
    else case (w[31:28])
      4'hA: tag = "R1";
      4'hB: tag = "R2";
      4'hC: tag = "R3";
      default: tag = "R4";
    endcase
    @(posedge clk);
    @(negedge clk);
    chk(redirectValid == nRv, tag, "redirectValid", {31'd0, redirectValid}, {31'd0, nRv});
    chk(redirectFromExec == nFe, tag, "redirectFromExec", {31'd0, redirectFromExec}, {31'd0, nFe});
    if (nRv) chk(redirectAddr == nAddr, tag, "redirectAddr", redirectAddr, nAddr);
    chk(dnValid == live, live ? "R6" : tag, "dnValid", {31'd0, dnValid}, {31'd0, live});
    chk(dnPredTaken == (live && pr), live ? tag : "R6", "dnPredTaken",
        {31'd0, dnPredTaken}, {31'd0, live && pr});
    if (live) begin
      chk(dnInsn == w, "R6", "dnInsn", dnInsn, w);
      chk(dnPc == p, "R6", "dnPc", dnPc, p);
    end
    expRv = nRv;
  endtask

  task automatic idle();
    step(1'b0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!redirectValid && !redirectFromExec && !dnValid && !dnPredTaken, "R11",
        "outputs in reset", {28'd0, redirectValid, redirectFromExec, dnValid, dnPredTaken}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    step(1'b1, 32'hA000_0010, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 0, 0); // R1 forward jump
    idle();
    step(1'b1, 32'hA0FF_FFFE, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 0, 0); // R1 backward jump
    idle();
    step(1'b1, 32'hB000_FFF0, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 0, 0); // R2 backward taken
    idle();
    step(1'b1, 32'hB000_0010, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 0, 0); // R2 forward not taken
    step(1'b1, 32'hC000_8000, 32'h0000_4000, 1'b0, 1'b0, 1'b0, 0, 0); // R3
    step(1'b1, 32'h1234_5678, 32'h0000_5000, 1'b0, 1'b0, 1'b0, 0, 0); // R4
    step(1'b1, 32'hA800_0040, 32'h0000_6000, 1'b0, 1'b0, 1'b0, 0, 0); // R5 absolute jump
    idle();
    step(1'b1, 32'hB800_FFFC, 32'h0000_6000, 1'b0, 1'b0, 1'b0, 0, 0); // R5 absolute cond
    idle();
    step(1'b0, 32'hA000_0010, 32'h0000_7000, 1'b1, 1'b0, 1'b1, 32'h0000_9000, 32'h0000_8000); // R7 taken miss
    step(1'b0, 32'd0, 32'd0, 1'b1, 1'b1, 1'b0, 32'h0000_9000, 32'h0000_8000); // R7 not-taken miss
    idle();
    step(1'b0, 32'd0, 32'd0, 1'b1, 1'b1, 1'b1, 32'h0000_9000, 32'h0000_8000); // R7 match
    step(1'b1, 32'hA000_0010, 32'h0000_7000, 1'b1, 1'b1, 1'b0, 0, 32'h0000_8800); // R8
    step(1'b1, 32'hA000_0010, 32'h0000_7100, 1'b0, 1'b0, 1'b0, 0, 0); // R10 squash
    step(1'b0, 32'hA000_0010, 32'h0000_7200, 1'b0, 1'b0, 1'b0, 0, 0); // R9

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] k;
      logic ev;
      case ($urandom_range(0, 3))
        0: k = 4'hA;
        1: k = 4'hB;
        2: k = 4'hC;
        default: k = 4'($urandom_range(0, 9));
      endcase
      w = $urandom;
      w[31:28] = k;
      w[27] = ($urandom_range(0, 3) == 0);
      ev = ($urandom_range(0, 3) == 0);
      step($urandom_range(0, 4) != 0, w, {$urandom, 2'b00} >> 2 << 2, ev,
           1'($urandom), 1'($urandom), {$urandom} & 32'hFFFF_FFFC,
           {$urandom} & 32'hFFFF_FFFC);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule